// File: doc/BRIEF.md
# Byte-Lane Logic Execute Unit

This block is an execute-stage datapath slice for a 32-bit core. It takes two register operands, a 16-bit immediate, a per-byte mask and a two-bit operation select. From these it produces one result word and a single flag that a branch unit reads.

It supports four operations. The first ANDs the first operand with the immediate placed in the upper half, with the lower half filled with ones. The second ORs the first operand with the immediate placed in the upper half. The third merges bytes from the two operands under the mask. The fourth is a lane compare, which produces a zero result; its flag is what the branch unit uses.

The lane-match flag is computed on every cycle, whatever the operation. The flag is 1 when at least one byte lane of the two operands holds equal values. A two-operand alias form, in which the destination register is also the first source, needs nothing different here. The output path is combinational by default. An optional register stage can be enabled by a parameter.

Top module: `bytelane_exec`

## Requirements
- R1: With op_sel = 2'b00, result equals rs_val AND {imm_val, 16'hFFFF}, so result[15:0] always equals rs_val[15:0].
- R2: With op_sel = 2'b01, result equals rs_val OR {imm_val, 16'h0000}, so result[15:0] always equals rs_val[15:0].
- R3: With op_sel = 2'b10, result byte i (bits 8i+7:8i, i = 0..3) is taken from rt_val when lane_mask[i] is 1 and from rs_val when it is 0; lane_mask[0] selects bits 7:0.
- R4: With op_sel = 2'b11, result is 32'h0 for every operand value.
- R5: lane_match is 1 when at least one byte lane of rs_val equals the same lane of rt_val.
- R6: lane_match is 0 when all four lane pairs differ.
- R7: lane_match depends only on rs_val and rt_val; it does not change with op_sel, imm_val or lane_mask.
- R8: With the default parameters, result and lane_match carry no X or Z bits for any op_sel value when the inputs are known. They follow the inputs in the same cycle, whatever the state of rst_n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register and for the checks |
| rst_n | input | 1 | Active-low reset of the optional output register |
| op_sel | input | 2 | Operation: 00 AND-upper-ones, 01 OR-upper, 10 merge, 11 lane compare |
| rs_val | input | 32 | First register operand |
| rt_val | input | 32 | Second register operand |
| imm_val | input | 16 | Upper-half immediate |
| lane_mask | input | 4 | Per-byte source select for the merge |
| result | output | 32 | Operation result |
| lane_match | output | 1 | 1 when any byte lane of rs_val equals that lane of rt_val |

## Verification
The bench builds the block with its defaults: a 32-bit word, 16-bit immediate, 8-bit lanes and the combinational output (REG_OUT = 0). That setting lets every result be compared in the same cycle that its inputs are applied. It also makes the check under R8, that held reset has no effect on the output, meaningful. Random operands are biased so that a chosen number of lanes match. Together with directed cases for one-lane and no-lane equality and for the empty, full and alternating masks, this covers the edges of the flag and of the merge.

// File: rtl/bytelane_pkg.sv
package bytelane_pkg;
   typedef enum logic [1:0] {
      OP_AND_HI_ONES = 2'b00,
      OP_OR_HI       = 2'b01,
      OP_MERGE       = 2'b10,
      OP_LANE_CMP    = 2'b11
   } bl_op_e;
endpackage

// File: rtl/bytelane_upper_logic.sv
module bytelane_upper_logic #(
   parameter int DATA_W = 32,
   parameter int IMM_W  = 16
) (
   input  logic [DATA_W-1:0] src,
   input  logic [IMM_W-1:0]  imm,
   output logic [DATA_W-1:0] and_out,
   output logic [DATA_W-1:0] or_out
);
   localparam int LOW_W = DATA_W - IMM_W;

   logic [DATA_W-1:0] hi_ones;
   logic [DATA_W-1:0] hi_zero;

   always_comb begin
      hi_ones = {imm, {LOW_W{1'b1}}};
      hi_zero = {imm, {LOW_W{1'b0}}};
      and_out = src & hi_ones;
      or_out  = src | hi_zero;
   end
endmodule

// File: rtl/bytelane_merge.sv
module bytelane_merge #(
   parameter int DATA_W = 32,
   parameter int LANE_W = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [DATA_W-1:0]        a_val,
   input  logic [DATA_W-1:0]        b_val,
   input  logic [DATA_W/LANE_W-1:0] sel,
   output logic [DATA_W-1:0]        merged
);
   localparam int N_LANES = DATA_W / LANE_W;

   for (genvar i = 0; i < N_LANES; i++) begin : g_lane
      assign merged[i*LANE_W +: LANE_W] = sel[i] ? b_val[i*LANE_W +: LANE_W]
                                                 : a_val[i*LANE_W +: LANE_W];
   end

   // R3: empty mask keeps the first operand, full mask keeps the second
   a_r3_mask_none: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == '0) |-> (merged == a_val));
   a_r3_mask_full: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == '1) |-> (merged == b_val));
endmodule

// File: rtl/bytelane_lane_cmp.sv
module bytelane_lane_cmp #(
   parameter int DATA_W = 32,
   parameter int LANE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] a_val,
   input  logic [DATA_W-1:0] b_val,
   output logic              any_eq
);
   localparam int N_LANES = DATA_W / LANE_W;

   logic [N_LANES-1:0] lane_eq;

   for (genvar i = 0; i < N_LANES; i++) begin : g_eq
      assign lane_eq[i] = (a_val[i*LANE_W +: LANE_W] == b_val[i*LANE_W +: LANE_W]);
   end

   assign any_eq = |lane_eq;

   // R5: identical operands always match
   a_r5_equal_words: assert property (@(posedge clk) disable iff (!rst_n)
      (a_val == b_val) |-> any_eq);
   // R6: a clear flag means the lowest lanes really differ
   a_r6_low_lane_differs: assert property (@(posedge clk) disable iff (!rst_n)
      !any_eq |-> (a_val[LANE_W-1:0] != b_val[LANE_W-1:0]));
endmodule

// File: rtl/bytelane_exec.sv
module bytelane_exec #(
   parameter int DATA_W  = 32,
   parameter int IMM_W   = 16,
   parameter int LANE_W  = 8,
   parameter bit REG_OUT = 1'b0
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [1:0]               op_sel,
   input  logic [DATA_W-1:0]        rs_val,
   input  logic [DATA_W-1:0]        rt_val,
   input  logic [IMM_W-1:0]         imm_val,
   input  logic [DATA_W/LANE_W-1:0] lane_mask,
   output logic [DATA_W-1:0]        result,
   output logic                     lane_match
);
   import bytelane_pkg::*;

   localparam int N_LANES = DATA_W / LANE_W;
   localparam int LOW_W   = DATA_W - IMM_W;

   if (DATA_W % LANE_W != 0) begin : g_bad_lane
      $error("DATA_W must be a whole number of lanes");
   end
   if (IMM_W <= 0 || IMM_W >= DATA_W) begin : g_bad_imm
      $error("IMM_W must be between 1 and DATA_W-1");
   end
   if (N_LANES < 1) begin : g_bad_count
      $error("at least one lane is required");
   end

   logic [DATA_W-1:0] and_res;
   logic [DATA_W-1:0] or_res;
   logic [DATA_W-1:0] merge_res;
   logic [DATA_W-1:0] result_c;
   logic              match_c;
   bl_op_e            op;

   assign op = bl_op_e'(op_sel);

   bytelane_upper_logic #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_upper (
      .src(rs_val), .imm(imm_val), .and_out(and_res), .or_out(or_res));

   bytelane_merge #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_merge (
      .clk(clk), .rst_n(rst_n), .a_val(rs_val), .b_val(rt_val),
      .sel(lane_mask), .merged(merge_res));

   bytelane_lane_cmp #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_cmp (
      .clk(clk), .rst_n(rst_n), .a_val(rs_val), .b_val(rt_val),
      .any_eq(match_c));

   always_comb begin
      unique case (op)
         OP_AND_HI_ONES: result_c = and_res;
         OP_OR_HI:       result_c = or_res;
         OP_MERGE:       result_c = merge_res;
         OP_LANE_CMP:    result_c = '0;
         default:        result_c = '0;
      endcase
   end

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            result     <= '0;
            lane_match <= 1'b0;
         end else begin
            result     <= result_c;
            lane_match <= match_c;
         end
      end
   end else begin : g_comb
      assign result     = result_c;
      assign lane_match = match_c;
   end

   // R1: the low half passes through untouched
   a_r1_and_low_pass: assert property (@(posedge clk) disable iff (!rst_n)
      (op_sel == 2'b00) |-> (result_c[LOW_W-1:0] == rs_val[LOW_W-1:0]));
   // R1: upper bits can only be cleared, never set
   a_r1_and_hi_subset: assert property (@(posedge clk) disable iff (!rst_n)
      (op_sel == 2'b00) |-> ((result_c[DATA_W-1:LOW_W] & ~rs_val[DATA_W-1:LOW_W]) == '0));
   // R2: the low half passes through and upper bits can only be set
   a_r2_or_low_pass: assert property (@(posedge clk) disable iff (!rst_n)
      (op_sel == 2'b01) |-> (result_c[LOW_W-1:0] == rs_val[LOW_W-1:0]));
   a_r2_or_hi_superset: assert property (@(posedge clk) disable iff (!rst_n)
      (op_sel == 2'b01) |-> ((rs_val & ~result_c) == '0));
   // R4: lane compare yields a zero word
   a_r4_cmp_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (op_sel == 2'b11) |-> (result_c == '0));
   // R8: no unknown bits for known inputs
   a_r8_known_out: assert property (@(posedge clk) disable iff (!rst_n)
      !$isunknown({op_sel, rs_val, rt_val, imm_val, lane_mask})
      |-> !$isunknown({result_c, match_c}));
endmodule

// File: tb/bytelane_exec_bench.sv
module bytelane_exec_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  op_sel = 2'b00;
   logic [31:0] rs_val = '0;
   logic [31:0] rt_val = '0;
   logic [15:0] imm_val = '0;
   logic [3:0]  lane_mask = '0;
   logic [31:0] result;
   logic        lane_match;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #4 clk = ~clk;

   bytelane_exec u_bytelane_exec (
      .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .rs_val(rs_val),
      .rt_val(rt_val), .imm_val(imm_val), .lane_mask(lane_mask),
      .result(result), .lane_match(lane_match));

   function automatic logic [31:0] exp_result(input logic [1:0] op, input logic [31:0] a,
                                              input logic [31:0] b, input logic [15:0] im,
                                              input logic [3:0] m);
      logic [31:0] r;
      case (op)
         2'b00: r = a & {im, 16'hFFFF};
         2'b01: r = a | {im, 16'h0000};
         2'b10: begin
            for (int k = 0; k < 4; k++)
               r[k*8 +: 8] = m[k] ? b[k*8 +: 8] : a[k*8 +: 8];
         end
         default: r = 32'h0;
      endcase
      return r;
   endfunction

   function automatic logic exp_match(input logic [31:0] a, input logic [31:0] b);
      logic hit = 1'b0;
      for (int k = 0; k < 4; k++)
         if (a[k*8 +: 8] == b[k*8 +: 8]) hit = 1'b1;
      return hit;
   endfunction

   task automatic check_res(input string req, input logic [31:0] exp);
      n_checks++;
      if (result !== exp) begin
         n_fail++;
         $display("FAIL %s result actual=%h expected=%h (op=%b rs=%h rt=%h imm=%h m=%b)",
                  req, result, exp, op_sel, rs_val, rt_val, imm_val, lane_mask);
      end
   endtask

   task automatic check_flag(input string req, input logic exp);
      n_checks++;
      if (lane_match !== exp) begin
         n_fail++;
         $display("FAIL %s lane_match actual=%b expected=%b (rs=%h rt=%h)",
                  req, lane_match, exp, rs_val, rt_val);
      end
   endtask

   task automatic apply(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b,
                        input logic [15:0] im, input logic [3:0] m);
      @(negedge clk);
      op_sel = op; rs_val = a; rt_val = b; imm_val = im; lane_mask = m;
      #1;
   endtask

   function automatic string op_req(input logic [1:0] op);
      case (op)
         2'b00:   return "R1";
         2'b01:   return "R2";
         2'b10:   return "R3";
         default: return "R4";
      endcase
   endfunction

   initial begin
      // R8: under held reset the outputs already follow the inputs
      apply(2'b01, 32'h0000_1234, 32'h0, 16'hA5A5, 4'h0);
      check_res("R8", 32'hA5A5_1234);
      apply(2'b00, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'h0F0F, 4'h0);
      check_res("R8", 32'h0F0F_FFFF);
      check_flag("R8", 1'b1);
      repeat (2) @(negedge clk);
      rst_n = 1'b1;

      // R1 directed: zero immediate clears the top half only
      apply(2'b00, 32'hDEAD_BEEF, 32'h0, 16'h0000, 4'hF);
      check_res("R1", 32'h0000_BEEF);
      // R2 directed: all-ones immediate sets the top half
      apply(2'b01, 32'h0000_0000, 32'h0, 16'hFFFF, 4'h0);
      check_res("R2", 32'hFFFF_0000);
      // R3 directed masks
      apply(2'b10, 32'h1111_1111, 32'hAABB_CCDD, 16'h0, 4'b0000);
      check_res("R3", 32'h1111_1111);
      apply(2'b10, 32'h1111_1111, 32'hAABB_CCDD, 16'h0, 4'b1111);
      check_res("R3", 32'hAABB_CCDD);
      apply(2'b10, 32'h1122_3344, 32'hAABB_CCDD, 16'h0, 4'b0001);
      check_res("R3", 32'h1122_33DD);
      apply(2'b10, 32'h1122_3344, 32'hAABB_CCDD, 16'h0, 4'b1010);
      check_res("R3", 32'hAA22_CC44);
      // R4 and R6: all lanes differ
      apply(2'b11, 32'h0102_0304, 32'h1020_3040, 16'hFFFF, 4'hF);
      check_res("R4", 32'h0);
      check_flag("R6", 1'b0);
      // R5: only the top lane equal, then only the bottom lane
      apply(2'b11, 32'h7F01_0203, 32'h7F10_2030, 16'h0, 4'h0);
      check_flag("R5", 1'b1);
      apply(2'b11, 32'h0102_03AA, 32'h1020_30AA, 16'h0, 4'h0);
      check_flag("R5", 1'b1);
      // R7: flag unchanged across every op, immediate and mask
      for (int op = 0; op < 4; op++) begin
         apply(op[1:0], 32'h0102_0304, 32'h1020_3040, 16'h1234 ^ 16'(op), 4'(op * 5));
         check_flag("R7", 1'b0);
         apply(op[1:0], 32'h0102_5504, 32'h1020_5540, 16'h4321, 4'(~op));
         check_flag("R7", 1'b1);
      end

      // Random phase with fixed seed
      void'($urandom(32'h5EED_1234));
      for (int n = 0; n < 400; n++) begin
         logic [1:0]  op = 2'($urandom_range(0, 3));
         logic [31:0] a  = $urandom;
         logic [31:0] b  = $urandom;
         logic [15:0] im = 16'($urandom);
         logic [3:0]  m  = 4'($urandom);
         logic [3:0]  force_eq = 4'($urandom);
         if (n % 3 == 0) begin
            for (int k = 0; k < 4; k++)
               if (force_eq[k]) b[k*8 +: 8] = a[k*8 +: 8];
         end else if (n % 3 == 1) begin
            for (int k = 0; k < 4; k++)
               if (b[k*8 +: 8] == a[k*8 +: 8]) b[k*8 +: 8] = ~a[k*8 +: 8];
         end
         apply(op, a, b, im, m);
         check_res(op_req(op), exp_result(op, a, b, im, m));
         check_flag(exp_match(a, b) ? "R5" : "R6", exp_match(a, b));
      end
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
         end
      join_any
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule